// File: doc/BRIEF.md
# Adjustable precision-time system timer

This block keeps a free-running time-of-day count, 54 bits wide, in units of 2^-8 ns. On every rising clock edge it adds a programmable increment to the count. The increment is 42 bits in units of 2^-40 ns. Its upper 10 bits are the coarse step, in units of 2^-8 ns, and they go straight onto the count. Its lower 32 bits are a sub-nanosecond fraction, which feeds a 32-bit carry accumulator. Each time that accumulator overflows, one extra count unit is added.

Four adjustments act on the timer:
- **Overwrite.** A control domain that is not synchronous to the timer clock can load a new count. It does so by flipping the level of a request line. The request is resynchronised inside the block. The new value is sampled only once the request has been recognised, and only if the load enable is high. If the request flip was first seen by the falling clock edge, half of the current increment is added to the loaded value to recover half a clock of phase.
- **Coarse set, fine trim and phase shift.** These three arrive through a strobed adjust port with a two-bit method code. A coarse set replaces the increment. A fine trim adds a signed amount to the increment. A phase shift enlarges a single timer step.

Top module: `ptime_counter`

## Requirements
- R1: While `rst` is high, `time_out` reads 0 and `incr_out` reads 42'h100_0000_0000.
- R2: On each rising edge without an overwrite, `time_out` grows by `incr_out[41:32]`, plus 1 when the 32-bit fraction accumulator (adding `incr_out[31:0]`) overflows. The count wraps modulo 2^54.
- R3: Method 2'b00 (coarse set) sampled with `adj_strobe` makes `incr_out` equal to {`adj_value[9:0]`, 32'b0} after that edge.
- R4: Method 2'b01 (fine trim) sampled with `adj_strobe` adds the sign-extended `adj_value` to `incr_out`, modulo 2^42. The sum stays in use afterwards.
- R5: Method 2'b10 (phase shift) sampled with `adj_strobe` adds `adj_value[17:0]` to the timer step of the next rising edge only. `incr_out` is not changed.
- R6: A phase-shift request sampled while a phase shift is still waiting to be applied is dropped.
- R7: A level change on `ld_toggle` is an overwrite request. With `ld_enable` high, `time_out` takes `ld_value` at the third rising edge after the change, and the fraction accumulator is cleared.
- R8: With `ld_enable` low, a level change on `ld_toggle` leaves `time_out` counting normally.
- R9: If the change on `ld_toggle` falls in the high phase of the clock, the loaded value becomes `ld_value` + `incr_out[41:33]`, and the accumulator starts at `incr_out[32:1]`. If the change falls in the low phase, nothing is added.
- R10: An overwrite takes the place of the normal step and of a waiting phase shift in the same cycle. That phase shift is discarded.
- R11: Method 2'b11 sampled with `adj_strobe` changes neither `incr_out` nor the timer step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_value | input | 54 | Count to load on an overwrite |
| ld_enable | input | 1 | Permits an overwrite request to load |
| ld_toggle | input | 1 | Overwrite request; any level change, asynchronous |
| adj_value | input | 32 | Adjust operand |
| adj_method | input | 2 | 00 coarse set, 01 fine trim, 10 phase shift, 11 none |
| adj_strobe | input | 1 | Adjust request, sampled on each rising edge |
| time_out | output | 54 | Current timer count, units of 2^-8 ns |
| incr_out | output | 42 | Current increment, units of 2^-40 ns |

## Verification
The assertions take two things for granted about the inputs. First, successive level changes on `ld_toggle` are several clock cycles apart, so that one change produces exactly one recognised request. Second, `ld_value` and `ld_enable` are held steady from before the change until the load edge. The stimulus respects both. It places every request flip a few nanoseconds after a chosen clock edge, which fixes whether the flip lands in the high or the low phase. It also waits at least four cycles between requests and never alters the load operands while a request is in flight.

// File: rtl/ptime_pkg.sv
package ptime_pkg;
    localparam int TIME_W   = 54;
    localparam int INC_W    = 42;
    localparam int FRAC_W   = 32;
    localparam int COARSE_W = INC_W - FRAC_W;
    localparam int ADJ_W    = 32;
    localparam int PHASE_W  = 18;
    localparam int METH_W   = 2;

    typedef enum logic [METH_W-1:0] {
        ADJ_COARSE = 2'b00,
        ADJ_FINE   = 2'b01,
        ADJ_PHASE  = 2'b10,
        ADJ_HOLD   = 2'b11
    } adj_op_e;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FRAC_W-1:0]   frac;
    } incr_t;

    typedef struct packed {
        logic fire;
        logic half;
    } load_evt_t;

    function automatic logic [INC_W-1:0] fine_ext(input logic [ADJ_W-1:0] v);
        return {{(INC_W-ADJ_W){v[ADJ_W-1]}}, v};
    endfunction
endpackage

// File: rtl/ptime_resync.sv
module ptime_resync
    import ptime_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tgl_async,
    output load_evt_t evt
);
    logic [STAGES-1:0] rise_sh;
    logic [STAGES-1:0] fall_sh;
    logic              rise_last;
    logic              fall_snap;

    // capture chain on the rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_sh   <= '0;
            rise_last <= 1'b0;
            fall_snap <= 1'b0;
        end else begin
            rise_sh   <= {rise_sh[STAGES-2:0], tgl_async};
            rise_last <= rise_sh[STAGES-1];
            fall_snap <= fall_sh[STAGES-1];
        end
    end

    // parallel chain on the falling edge, half a cycle ahead when it wins
    always_ff @(negedge clk) begin
        if (rst) fall_sh <= '0;
        else     fall_sh <= {fall_sh[STAGES-2:0], tgl_async};
    end

    always_comb begin
        evt.fire = rise_sh[STAGES-1] ^ rise_last;
        evt.half = evt.fire && (fall_snap == rise_sh[STAGES-1]);
    end

    // R7: one flip of the request yields a single load event
    p_single_fire_r7: assert property (@(posedge clk) disable iff (rst)
        evt.fire |=> !evt.fire);
endmodule

// File: rtl/ptime_incr.sv
module ptime_incr
    import ptime_pkg::*;
#(
    parameter logic [INC_W-1:0] RESET_INC = 42'h100_0000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adj_strobe,
    input  adj_op_e            adj_op,
    input  logic [ADJ_W-1:0]   adj_value,
    output incr_t              inc_q,
    output logic               phase_go,
    output logic [PHASE_W-1:0] phase_amt
);
    incr_t inc_d;

    always_comb begin
        inc_d = inc_q;
        if (adj_strobe) begin
            case (adj_op)
                ADJ_COARSE: begin
                    inc_d.coarse = adj_value[COARSE_W-1:0];
                    inc_d.frac   = '0;
                end
                ADJ_FINE: inc_d = incr_t'(INC_W'(inc_q) + fine_ext(adj_value));
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) inc_q <= incr_t'(RESET_INC);
        else     inc_q <= inc_d;
    end

    // one-shot phase request: held for exactly one timer update
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_go  <= 1'b0;
            phase_amt <= '0;
        end else if (adj_strobe && adj_op == ADJ_PHASE && !phase_go) begin
            phase_go  <= 1'b1;
            phase_amt <= adj_value[PHASE_W-1:0];
        end else begin
            phase_go  <= 1'b0;
        end
    end

    p_coarse_r3: assert property (@(posedge clk) disable iff (rst)
        (adj_strobe && adj_op == ADJ_COARSE) |=>
        (inc_q.frac == '0 && inc_q.coarse == $past(adj_value[COARSE_W-1:0])));

    p_fine_r4: assert property (@(posedge clk) disable iff (rst)
        (adj_strobe && adj_op == ADJ_FINE) |=>
        (INC_W'(inc_q) == INC_W'($past(INC_W'(inc_q)) + $past(fine_ext(adj_value)))));

    p_phase_once_r5: assert property (@(posedge clk) disable iff (rst)
        phase_go |=> !phase_go);

    p_phase_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_go && adj_strobe && adj_op == ADJ_PHASE) |=> $stable(phase_amt));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (adj_strobe && adj_op == ADJ_HOLD) |=> $stable(inc_q));
endmodule

// File: rtl/ptime_accum.sv
module ptime_accum
    import ptime_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  incr_t              inc,
    input  logic               phase_go,
    input  logic [PHASE_W-1:0] phase_amt,
    input  load_evt_t          evt,
    input  logic               ld_enable,
    input  logic [TIME_W-1:0]  ld_value,
    output logic [TIME_W-1:0]  time_q
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   frac_sum;
    logic [TIME_W-1:0] step;
    logic [TIME_W-1:0] half_add;
    logic [FRAC_W-1:0] half_frac;
    logic              do_load;

    assign do_load   = evt.fire && ld_enable;
    assign frac_sum  = {1'b0, acc_q} + {1'b0, inc.frac};
    assign step      = TIME_W'(inc.coarse) + TIME_W'(frac_sum[FRAC_W])
                     + (phase_go ? TIME_W'(phase_amt) : '0);
    assign half_add  = evt.half ? TIME_W'(inc.coarse >> 1) : '0;
    assign half_frac = evt.half ? {inc.coarse[0], inc.frac[FRAC_W-1:1]} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '0;
            acc_q  <= '0;
        end else if (do_load) begin
            time_q <= ld_value + half_add;
            acc_q  <= half_frac;
        end else begin
            time_q <= time_q + step;
            acc_q  <= frac_sum[FRAC_W-1:0];
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!do_load && !phase_go) |=>
        ((time_q - $past(time_q)) == TIME_W'($past(inc.coarse)) ||
         (time_q - $past(time_q)) == TIME_W'($past(inc.coarse)) + TIME_W'(1)));

    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        (do_load && !evt.half) |=> (time_q == $past(ld_value) && acc_q == '0));

    p_load_half_r9: assert property (@(posedge clk) disable iff (rst)
        (do_load && evt.half) |=>
        (time_q == $past(ld_value) + TIME_W'($past(inc.coarse) >> 1)));
endmodule

// File: rtl/ptime_counter.sv
module ptime_counter
    import ptime_pkg::*;
#(
    parameter logic [INC_W-1:0] RESET_INC   = 42'h100_0000_0000,
    parameter int               SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TIME_W-1:0]    ld_value,
    input  logic                 ld_enable,
    input  logic                 ld_toggle,
    input  logic [ADJ_W-1:0]     adj_value,
    input  logic [METH_W-1:0]    adj_method,
    input  logic                 adj_strobe,
    output logic [TIME_W-1:0]    time_out,
    output logic [INC_W-1:0]     incr_out
);
    load_evt_t          evt;
    incr_t              inc_q;
    logic               phase_go;
    logic [PHASE_W-1:0] phase_amt;

    ptime_resync #(.STAGES(SYNC_STAGES)) u_resync (
        .clk       (clk),
        .rst       (rst),
        .tgl_async (ld_toggle),
        .evt       (evt)
    );

    ptime_incr #(.RESET_INC(RESET_INC)) u_incr (
        .clk        (clk),
        .rst        (rst),
        .adj_strobe (adj_strobe),
        .adj_op     (adj_op_e'(adj_method)),
        .adj_value  (adj_value),
        .inc_q      (inc_q),
        .phase_go   (phase_go),
        .phase_amt  (phase_amt)
    );

    ptime_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .inc       (inc_q),
        .phase_go  (phase_go),
        .phase_amt (phase_amt),
        .evt       (evt),
        .ld_enable (ld_enable),
        .ld_value  (ld_value),
        .time_q    (time_out)
    );

    assign incr_out = inc_q;
endmodule

// File: tb/tb_ptime_counter.sv
module tb_ptime_counter;
    import ptime_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [TIME_W-1:0] ld_value = '0;
    logic              ld_enable = 1'b0;
    logic              ld_toggle = 1'b0;
    logic [ADJ_W-1:0]  adj_value = '0;
    logic [1:0]        adj_method = 2'b11;
    logic              adj_strobe = 1'b0;
    logic [TIME_W-1:0] time_out;
    logic [INC_W-1:0]  incr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ptime_counter dut (
        .clk(clk), .rst(rst), .ld_value(ld_value), .ld_enable(ld_enable),
        .ld_toggle(ld_toggle), .adj_value(adj_value), .adj_method(adj_method),
        .adj_strobe(adj_strobe), .time_out(time_out), .incr_out(incr_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic adjust(input logic [1:0] m, input logic [31:0] v);
        tick();
        adj_method = m; adj_value = v; adj_strobe = 1'b1;
        tick();
        adj_strobe = 1'b0;
    endtask

    // request flip in the low phase (no half-increment), load lands on 3rd edge
    task automatic load_low(input logic [TIME_W-1:0] v, input logic en);
        ld_value = v; ld_enable = en;
        @(negedge clk); #2;
        ld_toggle = ~ld_toggle;
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic load_high(input logic [TIME_W-1:0] v);
        ld_value = v; ld_enable = 1'b1;
        @(posedge clk); #5;
        ld_toggle = ~ld_toggle;
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk("R1 time", 64'(time_out), 64'h0);
        chk("R1 incr", 64'(incr_out), 64'h100_0000_0000);
        rst = 1'b0;
    endtask

    task automatic t_step();
        logic [TIME_W-1:0] t0;
        tick(); t0 = time_out;
        tick();
        chk("R2 step", 64'(time_out - t0), 64'h100);
    endtask

    task automatic t_coarse_hold();
        logic [TIME_W-1:0] t0;
        adjust(2'b01, 32'h0000_1234);
        adjust(2'b00, 32'hABCD_E0A0);
        chk("R3 coarse", 64'(incr_out), 64'h0A0_0000_0000);
        adjust(2'b11, 32'hFFFF_FFFF);
        chk("R11 hold incr", 64'(incr_out), 64'h0A0_0000_0000);
        t0 = time_out;
        tick();
        chk("R11 hold step", 64'(time_out - t0), 64'hA0);
    endtask

    task automatic t_fine();
        adjust(2'b00, 32'h0000_018D);
        adjust(2'b01, 32'h4562_E0A0);
        adjust(2'b01, 32'h4562_E0A0);
        chk("R4 fine add", 64'(incr_out), 64'h18D_8AC5_C140);
        adjust(2'b01, 32'hBA9D_1F60);
        chk("R4 fine sub", 64'(incr_out), 64'h18D_4562_E0A0);
    endtask

    task automatic t_carry();
        adjust(2'b00, 32'h0000_0002);
        adjust(2'b01, 32'h4000_0000);
        load_low(54'h1000, 1'b1);
        chk("R7 load", 64'(time_out), 64'h1000);
        repeat (4) tick();
        chk("R2 carry", 64'(time_out), 64'h1009);
        repeat (4) tick();
        chk("R2 carry again", 64'(time_out), 64'h1012);
    endtask

    task automatic t_half();
        adjust(2'b00, 32'h0000_00A0);
        load_high(54'h2_0000);
        chk("R9 high phase", 64'(time_out), 64'h2_0050);
        tick();
        chk("R2 after load", 64'(time_out), 64'h2_00F0);
        repeat (3) tick();
        load_low(54'h3_0000, 1'b1);
        chk("R9 low phase", 64'(time_out), 64'h3_0000);
    endtask

    task automatic t_disabled();
        logic [TIME_W-1:0] t0;
        ld_value = 54'h7_7777; ld_enable = 1'b0;
        repeat (3) tick();
        t0 = time_out;
        ld_toggle = ~ld_toggle;
        repeat (3) tick();
        chk("R8 no load", 64'(time_out), 64'(t0 + 54'd480));
        repeat (2) tick();
    endtask

    task automatic t_phase();
        logic [TIME_W-1:0] tj;
        tick();
        adj_method = 2'b10; adj_value = 32'hFFFF_FFFF; adj_strobe = 1'b1;
        tick();
        adj_strobe = 1'b0; tj = time_out;
        tick();
        chk("R5 shift", 64'(time_out), 64'(tj + 54'hA0 + 54'h3_FFFF));
        tick();
        chk("R5 one shot", 64'(time_out), 64'(tj + 54'h140 + 54'h3_FFFF));
        chk("R5 incr kept", 64'(incr_out), 64'h0A0_0000_0000);
        // back-to-back requests: the second one is dropped
        adj_method = 2'b10; adj_value = 32'h0000_0100; adj_strobe = 1'b1;
        tick();
        tj = time_out;
        tick();
        adj_strobe = 1'b0;
        chk("R6 first", 64'(time_out), 64'(tj + 54'hA0 + 54'h100));
        tick();
        chk("R6 second dropped", 64'(time_out), 64'(tj + 54'h140 + 54'h100));
    endtask

    task automatic t_priority();
        ld_value = 54'h5_0000; ld_enable = 1'b1;
        @(negedge clk); #2;
        ld_toggle = ~ld_toggle;
        tick();
        adj_method = 2'b10; adj_value = 32'h0000_1000; adj_strobe = 1'b1;
        tick();
        adj_strobe = 1'b0;
        tick();
        chk("R10 load wins", 64'(time_out), 64'h5_0000);
        tick();
        chk("R10 shift dropped", 64'(time_out), 64'h5_00A0);
    endtask

    task automatic t_wrap();
        repeat (3) tick();
        load_low(54'h3F_FFFF_FFFF_FFF0, 1'b1);
        chk("R7 load top", 64'(time_out), 64'h3F_FFFF_FFFF_FFF0);
        tick();
        chk("R2 wrap", 64'(time_out), 64'h90);
    endtask

    initial begin
        t_reset();
        t_step();
        t_coarse_hold();
        t_fine();
        t_carry();
        t_half();
        t_disabled();
        t_phase();
        t_priority();
        t_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule